// File: doc/BRIEF.md
# Presettable Split Decade Counter

This block is a four-bit counter made of two independent stages. The lowest bit `q[0]` is a divide-by-two stage driven by count input `cp0`. The upper three bits `q[3:1]` form a divide-by-five stage driven by a second count input `cp1`. With parameter `UPPER_MOD` set to 8, the upper stage divides by eight instead. The stages are chained outside the block:

- Feeding `q[0]` into `cp1` and counting at `cp0` gives a BCD decade count. With `UPPER_MOD` at 8, the same wiring gives a modulo-16 binary count.
- Feeding `q[3]` into `cp0` and counting at `cp1` gives the bi-quinary order. In that order `q[0]` is a divide-by-ten output that is high for exactly half of the period.

`cp0` and `cp1` are treated as slow asynchronous signals. Each passes through a `SYNC_STAGES`-deep synchronizer clocked by `clk`. Each high-to-low transition yields one count step, applied `SYNC_STAGES` system-clock edges after the first `clk` edge that samples the low level.

The active-low master reset `mr_n` clears everything without a clock and wins over every other input. The active-low load `ld_n` makes the outputs follow `p` at once and suppresses counting. When `ld_n` returns high, the last loaded value is kept and counting resumes from it. The block can therefore also serve as a four-bit transparent latch.

Top module: `split_decade_counter`

## Requirements
- R1: While `mr_n` is 0, `q` is 4'b0000 at once, with no clock edge needed, and the counter state is cleared.
- R2: When `mr_n` and `ld_n` are both 0, `q` stays 4'b0000. If `mr_n` is then released while `ld_n` is still 0, `q` equals `p`.
- R3: Each high-to-low transition of `cp0` inverts `q[0]` exactly once. A rising transition has no effect.
- R4: Each high-to-low transition of `cp1` advances the value `{q[3],q[2],q[1]}` through 0, 1, 2, 3, 4 and then back to 0 (with `UPPER_MOD`=5).
- R5: If the upper stage holds 5, 6 or 7 (with `UPPER_MOD`=5), the next `cp1` fall sets it to 0.
- R6: While `ld_n` is 0, `q` equals `p` with no clock edge needed. Falling edges on `cp0` or `cp1` do not change the value held.
- R7: After `ld_n` returns to 1, `q` keeps the last value of `p` until a count edge arrives, and counting continues from that value.
- R8: With `cp1` driven from `q[0]`, successive `cp0` falls from reset step `q` through 0 to 9 and then wrap to 0.
- R9: With `cp0` driven from `q[3]`, `q[0]` changes once every five `cp1` falls. It is 0 after falls 1 to 4 and 1 after falls 5 to 9, a divide-by-ten output with 50% duty cycle.
- R10: With `UPPER_MOD`=8 and `cp1` driven from `q[0]`, successive `cp0` falls step `q` through 0 to 15 and wrap to 0.
- R11: While no count edge and no load occur, `q` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| mr_n | input | 1 | Master reset, active low, asynchronous, top priority |
| ld_n | input | 1 | Parallel load, active low, transparent while low |
| cp0 | input | 1 | Count input of the divide-by-two stage, falling edge active |
| cp1 | input | 1 | Count input of the upper stage, falling edge active |
| p | input | 4 | Parallel data, `p[0]` to the low stage, `p[3:1]` to the upper stage |
| q | output | 4 | Counter outputs |

## Verification
The following properties are checked on every cycle:

- a detected `cp0` fall always inverts `q[0]`;
- a detected `cp1` fall always moves the upper stage to its successor, and with `UPPER_MOD`=5 the stage never leaves the range 0 to 4 after such a step;
- releasing the load leaves exactly the last sampled data;
- a quiet cycle leaves `q` unchanged.

Some behaviours need external wiring or a long sequence of events, so only the directed scenarios can show them: the BCD wrap from 9 to 0, the bi-quinary duty cycle, the modulo-16 variant, recovery from upper values 5 to 7, and reset winning over a simultaneous load.

// File: rtl/split_decade_counter.sv
module split_decade_counter #(
  parameter int SYNC_STAGES = 2,
  parameter int UPPER_MOD   = 5
) (
  input  logic       clk,
  input  logic       mr_n,
  input  logic       ld_n,
  input  logic       cp0,
  input  logic       cp1,
  input  logic [3:0] p,
  output logic [3:0] q
);

  localparam logic [2:0] UPPER_LAST = 3'(UPPER_MOD - 1);

  // bit SYNC_STAGES holds the previous synchronized level
  logic [SYNC_STAGES:0] sh0, sh1;
  logic                 adv0, adv1;
  logic                 lo;
  logic [2:0]           hi, hi_next;

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      sh0 <= '0;
      sh1 <= '0;
    end else begin
      sh0 <= {sh0[SYNC_STAGES-1:0], cp0};
      sh1 <= {sh1[SYNC_STAGES-1:0], cp1};
    end
  end

  assign adv0 = sh0[SYNC_STAGES] & ~sh0[SYNC_STAGES-1];
  assign adv1 = sh1[SYNC_STAGES] & ~sh1[SYNC_STAGES-1];

  assign hi_next = (hi >= UPPER_LAST) ? 3'd0 : hi + 3'd1;

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      lo <= 1'b0;
      hi <= 3'd0;
    end else if (!ld_n) begin
      lo <= p[0];
      hi <= p[3:1];
    end else begin
      if (adv0) lo <= ~lo;
      if (adv1) hi <= hi_next;
    end
  end

  assign q = !mr_n ? 4'd0 : (!ld_n ? p : {hi, lo});

endmodule

module split_decade_counter_chk #(
  parameter int UPPER_MOD = 5
) (
  input logic       clk,
  input logic       mr_n,
  input logic       ld_n,
  input logic       adv0,
  input logic       adv1,
  input logic [3:0] p,
  input logic [3:0] q
);

  localparam logic [2:0] LAST = 3'(UPPER_MOD - 1);

  logic started;
  always_ff @(posedge clk or negedge mr_n)
    if (!mr_n) started <= 1'b0;
    else       started <= 1'b1;

  // R3
  a_r3_low_toggles: assert property (@(posedge clk) disable iff (!mr_n)
    started && $past(mr_n) && $past(ld_n) && ld_n && $past(adv0)
    |-> q[0] != $past(q[0]));

  // R4
  a_r4_upper_steps: assert property (@(posedge clk) disable iff (!mr_n)
    started && $past(mr_n) && $past(ld_n) && ld_n && $past(adv1)
    |-> q[3:1] == (($past(q[3:1]) >= LAST) ? 3'd0 : $past(q[3:1]) + 3'd1));

  // R5
  a_r5_upper_in_range: assert property (@(posedge clk) disable iff (!mr_n)
    started && $past(mr_n) && $past(ld_n) && ld_n && $past(adv1)
    |-> q[3:1] <= LAST);

  // R7
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!mr_n)
    started && $past(mr_n) && !$past(ld_n) && ld_n
    |-> q == $past(p));

  // R11
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!mr_n)
    started && $past(mr_n) && $past(ld_n) && ld_n && !$past(adv0) && !$past(adv1)
    |-> $stable(q));

endmodule

bind split_decade_counter split_decade_counter_chk #(.UPPER_MOD(UPPER_MOD)) chk_i (
  .clk(clk), .mr_n(mr_n), .ld_n(ld_n), .adv0(adv0), .adv1(adv1), .p(p), .q(q)
);

// File: tb/split_decade_counter_tb_top.sv
`timescale 1ns/1ps
module split_decade_counter_tb_top;

  logic       clk = 1'b0;
  logic       mr_n = 1'b0;
  logic       ld_n = 1'b1;
  logic       cp0_drv = 1'b1;
  logic       cp1_drv = 1'b1;
  logic [3:0] p = 4'd0;
  logic [1:0] mode = 2'd0;   // 0 direct, 1 BCD chain, 2 bi-quinary chain
  logic       cp0, cp1, cp1_b;
  logic [3:0] q, q8;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign cp0   = (mode == 2'd2) ? q[3] : cp0_drv;
  assign cp1   = (mode == 2'd1) ? q[0] : cp1_drv;
  assign cp1_b = q8[0];

  split_decade_counter dut_i (
    .clk(clk), .mr_n(mr_n), .ld_n(ld_n), .cp0(cp0), .cp1(cp1), .p(p), .q(q));

  split_decade_counter #(.UPPER_MOD(8)) dut8_i (
    .clk(clk), .mr_n(mr_n), .ld_n(ld_n), .cp0(cp0), .cp1(cp1_b), .p(p), .q(q8));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mr_n = 1'b0; ld_n = 1'b1; cp0_drv = 1'b1; cp1_drv = 1'b1; mode = m;
    wait_clk(3);
    mr_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic fall0();
    cp0_drv = 1'b0; wait_clk(8);
    cp0_drv = 1'b1; wait_clk(8);
  endtask

  task automatic fall1();
    cp1_drv = 1'b0; wait_clk(8);
    cp1_drv = 1'b1; wait_clk(8);
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    check("R1 reset state", q, 4'd0);
    fall0(); fall1(); fall1();
    check("R1 pre-count", q, 4'b0101);
    #1 mr_n = 1'b0;
    #0.5 check("R1 async clear", q, 4'd0);
    wait_clk(2);
    mr_n = 1'b1;
    wait_clk(3);
    check("R1 state cleared", q, 4'd0);
  endtask

  task automatic t_reset_vs_load();
    do_reset(2'd0);
    p = 4'd9; ld_n = 1'b0; mr_n = 1'b0;
    #1 check("R2 reset wins", q, 4'd0);
    wait_clk(3);
    check("R2 reset wins held", q, 4'd0);
    mr_n = 1'b1;
    #1 check("R2 load after reset", q, 4'd9);
    wait_clk(2);
    ld_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_low_stage();
    do_reset(2'd0);
    cp0_drv = 1'b0; wait_clk(8);
    check("R3 toggle on fall", q, 4'b0001);
    cp0_drv = 1'b1; wait_clk(8);
    check("R3 rise ignored", q, 4'b0001);
    fall0();
    check("R3 second fall", q, 4'b0000);
  endtask

  task automatic t_upper_stage();
    do_reset(2'd0);
    for (int i = 1; i <= 7; i++) begin
      fall1();
      check("R4 upper sequence", q, 4'((i % 5) << 1));
    end
  endtask

  task automatic t_illegal_upper();
    do_reset(2'd0);
    for (int v = 5; v <= 7; v++) begin
      p = 4'((v << 1) | 1);
      ld_n = 1'b0; wait_clk(2); ld_n = 1'b1; wait_clk(2);
      check("R5 loaded value", q, 4'((v << 1) | 1));
      fall1();
      check("R5 return to 0", q, 4'b0001);
    end
  endtask

  task automatic t_load();
    do_reset(2'd0);
    p = 4'b0110; ld_n = 1'b0;
    #1 check("R6 follows p", q, 4'b0110);
    fall0(); fall1();
    check("R6 counting blocked", q, 4'b0110);
    p = 4'b1001;
    #1 check("R6 follows new p", q, 4'b1001);
    wait_clk(2);
    ld_n = 1'b1;
    wait_clk(20);
    check("R7 latched", q, 4'b1001);
    check("R11 quiet hold", q, 4'b1001);
    p = 4'b0000;
    wait_clk(3);
    check("R7 p ignored after release", q, 4'b1001);
    fall0();
    check("R7 resume low", q, 4'b1000);
    fall1();
    check("R7 resume upper", q, 4'b0000);
  endtask

  task automatic t_bcd();
    do_reset(2'd1);
    for (int i = 1; i <= 12; i++) begin
      fall0();
      check("R8 BCD count", q, 4'(i % 10));
    end
  endtask

  task automatic t_biquinary();
    int highs;
    highs = 0;
    do_reset(2'd2);
    for (int i = 1; i <= 20; i++) begin
      fall1();
      check("R9 biquinary q0", {3'b000, q[0]}, 4'((i / 5) % 2));
      if (q[0]) highs++;
    end
    check("R9 duty cycle", 4'(highs), 4'd10);
  endtask

  task automatic t_binary();
    do_reset(2'd0);
    for (int i = 1; i <= 18; i++) begin
      fall0();
      check("R10 modulo-16 count", q8, 4'(i % 16));
    end
  endtask

  initial begin
    t_reset();
    t_reset_vs_load();
    t_low_stage();
    t_upper_stage();
    t_illegal_upper();
    t_load();
    t_bcd();
    t_biquinary();
    t_binary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule